// File: doc/BRIEF.md
# Single-Port Indexed Video Control Register Bank

This block is the processor-facing control front of a video gate array. All indexed control registers sit behind a single write port. An internal phase toggle chooses what each write does. When the toggle is in index phase, the written byte becomes the register pointer. When it is in data phase, the byte goes to the register the pointer selects. Every write flips the phase. A read of the status port puts the toggle back into index phase, so software can always resynchronise before it starts a new index/data pair.

The indexed bank holds the following registers:

- a primary mode byte, which carries the video enable, blink, graphics and 16-colour flags;
- a border colour byte;
- a secondary mode byte, which carries the 2-colour flag;
- an extended-memory enable;
- sixteen 4-bit palette entries.

A separate page register, written through its own strobe, holds three fields: the display bank, the processor bank and a 2-bit line mask. From the line mask the block derives an address mask and an address shift for the memory mapper. It also reports each bank as a 16 KB page number and as a base address.

Top module: `gate_array_ctl`

## Requirements
- R1: After reset the phase is index, and the following outputs are zero: primary mode, border, secondary mode, extended enable and all palette entries. Both banks read 7, the line mask reads 0, the address mask is all ones and the shift is 0.
- R2: A port write in index phase loads the register pointer and changes no output. Every port write flips the phase, so successive writes alternate between pointer and data.
- R3: A status read forces index phase. A port write in the same cycle is still handled using the phase it found.
- R4: Index 0x00 stores the primary mode byte. Bit 1 drives graphics select, bit 3 drives video enable, bit 4 drives 16-colour select and bit 5 drives blink enable.
- R5: Index 0x02 stores the border byte. Index 0x03 stores the secondary mode byte, whose bit 3 drives 2-colour select.
- R6: Index 0x05 bit 0 is the extended-memory enable. While it is set, the line mask reads 0. Setting it discards the stored mask, which stays 0 after the enable is cleared until the page register is written again.
- R7: Indexes 0x10 to 0x1F write palette entries 0 to 15 and keep only data bits 3:0.
- R8: A data write to any other index changes no output.
- R9: Page register bits 7:6 are the line mask, bits 5:3 the processor bank and bits 2:0 the display bank. When written bit 7 is 1, bit 0 of both bank fields is stored as 0.
- R10: A nonzero line mask gives an address mask of 0x1FFF and a shift of 13. A zero mask gives an all-ones address mask and a shift of 0.
- R11: Each bank base output equals the bank number times 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_wr_i | input | 1 | Write strobe of the shared index/data port |
| port_data_i | input | 8 | Shared port write data |
| status_rd_i | input | 1 | Status port read strobe, resets phase |
| page_wr_i | input | 1 | Page register write strobe |
| page_data_i | input | 8 | Page register write data |
| mode1_o | output | 8 | Primary mode byte |
| video_en_o | output | 1 | Video output enable |
| blink_en_o | output | 1 | Blink enable |
| gfx_o | output | 1 | Graphics select |
| gfx16_o | output | 1 | 16-colour graphics select |
| border_o | output | 8 | Border colour |
| mode2_o | output | 8 | Secondary mode byte |
| two_color_o | output | 1 | 2-colour graphics select |
| ext_ram_o | output | 1 | Extended memory enable |
| pal_o | output | 64 | Palette, entry n at bits 4n+3:4n |
| line_mask_o | output | 2 | Effective line mask |
| disp_bank_o | output | 3 | Display bank, 16 KB page number |
| cpu_bank_o | output | 3 | Processor bank, 16 KB page number |
| addr_mask_o | output | 17 | Address mask |
| line_shift_o | output | 5 | Address shift |
| disp_base_o | output | 17 | Display bank base address |
| cpu_base_o | output | 17 | Processor bank base address |

## Verification
The bench builds the block with its default parameters: 8-bit data, sixteen 4-bit palette entries, 3-bit banks and 16 KB pages. These values give a 17-bit address and place the narrow mask at 13 bits. They also reach both ends of the palette window, both even-forced bank values and the top bank. With them, every mix of line-mask value and extended enable can be shown at the ports.

// File: rtl/gac_pkg.sv
package gac_pkg;
  localparam logic [7:0] IDX_MODE1  = 8'h00;
  localparam logic [7:0] IDX_BORDER = 8'h02;
  localparam logic [7:0] IDX_MODE2  = 8'h03;
  localparam logic [7:0] IDX_EXTRAM = 8'h05;
  localparam logic [7:0] IDX_PAL    = 8'h10;

  typedef enum logic {PH_INDEX = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/gac_port_seq.sv
module gac_port_seq
  import gac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_status_i,
  input  logic [IDX_W-1:0] data_i,
  output logic             reg_we_o,
  output logic [IDX_W-1:0] reg_idx_o
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_INDEX;
      idx_q   <= '0;
    end else begin
      if (wr_i && phase_q == PH_INDEX) idx_q <= data_i;
      if (rd_status_i)  phase_q <= PH_INDEX;
      else if (wr_i)    phase_q <= (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
    end
  end

  assign reg_we_o  = wr_i && (phase_q == PH_DATA);
  assign reg_idx_o = idx_q;

  // R2
  phase_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_status_i) |=> (phase_q != $past(phase_q)));
  // R3
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_i |=> (phase_q == PH_INDEX));
endmodule

// File: rtl/gac_ctl_regs.sv
module gac_ctl_regs
  import gac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAL_N  = 16,
  parameter int PAL_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [DATA_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [DATA_W-1:0]      mode1_o,
  output logic [DATA_W-1:0]      border_o,
  output logic [DATA_W-1:0]      mode2_o,
  output logic                   ext_ram_o,
  output logic [PAL_N*PAL_W-1:0] pal_o
);
  logic [DATA_W-1:0] mode1_q, border_q, mode2_q;
  logic              ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode1_q  <= '0;
      border_q <= '0;
      mode2_q  <= '0;
      ext_q    <= 1'b0;
    end else if (we_i) begin
      case (idx_i)
        DATA_W'(IDX_MODE1):  mode1_q  <= data_i;
        DATA_W'(IDX_BORDER): border_q <= data_i;
        DATA_W'(IDX_MODE2):  mode2_q  <= data_i;
        DATA_W'(IDX_EXTRAM): ext_q    <= data_i[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < PAL_N; g++) begin : g_pal
    localparam logic [DATA_W-1:0] ENTRY_IDX = DATA_W'(IDX_PAL) + DATA_W'(g);
    logic [PAL_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ent_q <= '0;
      else if (we_i && idx_i == ENTRY_IDX) ent_q <= data_i[PAL_W-1:0];
    end
    assign pal_o[g*PAL_W +: PAL_W] = ent_q;
  end

  assign mode1_o   = mode1_q;
  assign border_o  = border_q;
  assign mode2_o   = mode2_q;
  assign ext_ram_o = ext_q;

  // R8
  pal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pal_o));
  // R2
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mode1_o) && $stable(border_o) && $stable(mode2_o) && $stable(ext_ram_o)));
endmodule

// File: rtl/gac_page_reg.sv
module gac_page_reg #(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 3,
  parameter int PAGE_W     = 14,
  parameter int LINE_SHIFT = 13,
  parameter int ADDR_W     = BANK_W + PAGE_W,
  parameter int SHIFT_W    = $clog2(ADDR_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               page_wr_i,
  input  logic [DATA_W-1:0]  page_data_i,
  input  logic               ext_ram_i,
  output logic [1:0]         line_mask_o,
  output logic [BANK_W-1:0]  disp_bank_o,
  output logic [BANK_W-1:0]  cpu_bank_o,
  output logic [ADDR_W-1:0]  addr_mask_o,
  output logic [SHIFT_W-1:0] line_shift_o,
  output logic [ADDR_W-1:0]  disp_base_o,
  output logic [ADDR_W-1:0]  cpu_base_o
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'((64'd1 << LINE_SHIFT) - 64'd1);
  localparam int LM_LO = DATA_W - 2;

  logic [1:0]        lm_q;
  logic [BANK_W-1:0] db_q, cb_q, db_d, cb_d;
  logic              even_only;

  always_comb begin
    even_only = page_data_i[DATA_W-1];
    db_d = page_data_i[BANK_W-1:0];
    cb_d = page_data_i[2*BANK_W-1:BANK_W];
    if (even_only) begin
      db_d[0] = 1'b0;
      cb_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lm_q <= '0;
      db_q <= '1;
      cb_q <= '1;
    end else begin
      if (page_wr_i) begin
        lm_q <= page_data_i[LM_LO +: 2];
        db_q <= db_d;
        cb_q <= cb_d;
      end
      // extended memory discards the stored mask
      if (ext_ram_i) lm_q <= '0;
    end
  end

  assign line_mask_o  = ext_ram_i ? 2'b00 : lm_q;
  assign addr_mask_o  = (line_mask_o != 2'b00) ? NARROW_MASK : '1;
  assign line_shift_o = (line_mask_o != 2'b00) ? SHIFT_W'(LINE_SHIFT) : '0;
  assign disp_bank_o  = db_q;
  assign cpu_bank_o   = cb_q;
  assign disp_base_o  = {db_q, {PAGE_W{1'b0}}};
  assign cpu_base_o   = {cb_q, {PAGE_W{1'b0}}};

  // R6
  ext_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ext_ram_i) && !$past(page_wr_i)) |-> (line_mask_o == 2'b00));
  // R9
  even_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_wr_i && page_data_i[DATA_W-1]) |=> (!disp_bank_o[0] && !cpu_bank_o[0]));
  // R9
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_wr_i |=> ($stable(disp_bank_o) && $stable(cpu_bank_o)));
endmodule

// File: rtl/gate_array_ctl.sv
module gate_array_ctl #(
  parameter int DATA_W     = 8,
  parameter int PAL_N      = 16,
  parameter int PAL_W      = 4,
  parameter int BANK_W     = 3,
  parameter int PAGE_W     = 14,
  parameter int LINE_SHIFT = 13,
  localparam int ADDR_W    = BANK_W + PAGE_W,
  localparam int SHIFT_W   = $clog2(ADDR_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   port_wr_i,
  input  logic [DATA_W-1:0]      port_data_i,
  input  logic                   status_rd_i,
  input  logic                   page_wr_i,
  input  logic [DATA_W-1:0]      page_data_i,
  output logic [DATA_W-1:0]      mode1_o,
  output logic                   video_en_o,
  output logic                   blink_en_o,
  output logic                   gfx_o,
  output logic                   gfx16_o,
  output logic [DATA_W-1:0]      border_o,
  output logic [DATA_W-1:0]      mode2_o,
  output logic                   two_color_o,
  output logic                   ext_ram_o,
  output logic [PAL_N*PAL_W-1:0] pal_o,
  output logic [1:0]             line_mask_o,
  output logic [BANK_W-1:0]      disp_bank_o,
  output logic [BANK_W-1:0]      cpu_bank_o,
  output logic [ADDR_W-1:0]      addr_mask_o,
  output logic [SHIFT_W-1:0]     line_shift_o,
  output logic [ADDR_W-1:0]      disp_base_o,
  output logic [ADDR_W-1:0]      cpu_base_o
);
  logic              reg_we;
  logic [DATA_W-1:0] reg_idx;

  gac_port_seq #(.IDX_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (port_wr_i),
    .rd_status_i (status_rd_i),
    .data_i      (port_data_i),
    .reg_we_o    (reg_we),
    .reg_idx_o   (reg_idx)
  );

  gac_ctl_regs #(.DATA_W(DATA_W), .PAL_N(PAL_N), .PAL_W(PAL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we),
    .idx_i     (reg_idx),
    .data_i    (port_data_i),
    .mode1_o   (mode1_o),
    .border_o  (border_o),
    .mode2_o   (mode2_o),
    .ext_ram_o (ext_ram_o),
    .pal_o     (pal_o)
  );

  gac_page_reg #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W),
    .LINE_SHIFT(LINE_SHIFT), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)
  ) u_page (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .page_wr_i    (page_wr_i),
    .page_data_i  (page_data_i),
    .ext_ram_i    (ext_ram_o),
    .line_mask_o  (line_mask_o),
    .disp_bank_o  (disp_bank_o),
    .cpu_bank_o   (cpu_bank_o),
    .addr_mask_o  (addr_mask_o),
    .line_shift_o (line_shift_o),
    .disp_base_o  (disp_base_o),
    .cpu_base_o   (cpu_base_o)
  );

  assign gfx_o       = mode1_o[1];
  assign video_en_o  = mode1_o[3];
  assign gfx16_o     = mode1_o[4];
  assign blink_en_o  = mode1_o[5];
  assign two_color_o = mode2_o[3];

  // R4
  mode_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we && reg_idx == 8'h00) |=> (video_en_o == $past(port_data_i[3])));
endmodule

// File: tb/gate_array_ctl_tb.sv
module gate_array_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SNAP_W = 158;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_wr = 1'b0, status_rd = 1'b0, page_wr = 1'b0;
  logic [7:0] port_data = '0, page_data = '0;

  logic [7:0]  mode1, border, mode2;
  logic        video_en, blink_en, gfx, gfx16, two_color, ext_ram;
  logic [63:0] pal;
  logic [1:0]  line_mask;
  logic [2:0]  disp_bank, cpu_bank;
  logic [16:0] addr_mask, disp_base, cpu_base;
  logic [4:0]  line_shift;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_array_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_wr_i(port_wr), .port_data_i(port_data),
    .status_rd_i(status_rd), .page_wr_i(page_wr), .page_data_i(page_data),
    .mode1_o(mode1), .video_en_o(video_en), .blink_en_o(blink_en), .gfx_o(gfx),
    .gfx16_o(gfx16), .border_o(border), .mode2_o(mode2), .two_color_o(two_color),
    .ext_ram_o(ext_ram), .pal_o(pal), .line_mask_o(line_mask),
    .disp_bank_o(disp_bank), .cpu_bank_o(cpu_bank), .addr_mask_o(addr_mask),
    .line_shift_o(line_shift), .disp_base_o(disp_base), .cpu_base_o(cpu_base)
  );

  wire [SNAP_W-1:0] act = {video_en, blink_en, gfx, gfx16, mode1, border, mode2,
                           two_color, ext_ram, pal, line_mask, disp_bank, cpu_bank,
                           addr_mask, line_shift, disp_base, cpu_base};

  // reference model built from the requirements
  logic [7:0] m_mode1 = '0, m_border = '0, m_mode2 = '0, m_idx = '0;
  logic       m_ext = 1'b0, m_phase = 1'b0;
  logic [3:0] m_pal [16];
  logic [1:0] m_lm = '0;
  logic [2:0] m_db = 3'd7, m_cb = 3'd7;

  function automatic logic [SNAP_W-1:0] snap();
    logic [63:0] p;
    logic [1:0]  lm;
    for (int i = 0; i < 16; i++) p[i*4 +: 4] = m_pal[i];
    lm = m_ext ? 2'b00 : m_lm;
    return {m_mode1[3], m_mode1[5], m_mode1[1], m_mode1[4], m_mode1, m_border, m_mode2,
            m_mode2[3], m_ext, p, lm, m_db, m_cb,
            (lm != 0) ? 17'h01FFF : 17'h1FFFF, (lm != 0) ? 5'd13 : 5'd0,
            {m_db, 14'd0}, {m_cb, 14'd0}};
  endfunction

  typedef struct {
    string            tag;
    logic [SNAP_W-1:0] exp;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic op(input bit wr, input bit rd, input bit pg, input logic [7:0] d,
                    input string tag);
    @(negedge clk);
    port_wr = wr; status_rd = rd; page_wr = pg; port_data = d; page_data = d;
    @(posedge clk);
    #1;
    port_wr = 1'b0; status_rd = 1'b0; page_wr = 1'b0;
    if (wr) begin
      if (!m_phase) m_idx = d;
      else begin
        case (m_idx)
          8'h00: m_mode1 = d;
          8'h02: m_border = d;
          8'h03: m_mode2 = d;
          8'h05: begin m_ext = d[0]; if (d[0]) m_lm = 2'b00; end
          default: if (m_idx >= 8'h10 && m_idx <= 8'h1F) m_pal[m_idx[3:0]] = d[3:0];
        endcase
      end
      m_phase = ~m_phase;
    end
    if (rd) m_phase = 1'b0;
    if (pg) begin
      m_lm = m_ext ? 2'b00 : d[7:6];
      m_db = d[7] ? {d[2:1], 1'b0} : d[2:0];
      m_cb = d[7] ? {d[5:4], 1'b0} : d[5:3];
    end
    sb_q.push_back('{tag, snap()});
  endtask

  task automatic pw(input logic [7:0] idx, input logic [7:0] d, input string tag);
    op(1'b1, 1'b0, 1'b0, idx, tag);
    op(1'b1, 1'b0, 1'b0, d, tag);
  endtask

  // monitor: compares each queued expectation at the following falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_pal[i] = 4'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sb_q.push_back('{"R1 reset", snap()});

    op(1'b1, 1'b0, 1'b0, 8'h02, "R2 index only");
    op(1'b1, 1'b0, 1'b0, 8'h5A, "R5 border");
    pw(8'h00, 8'h3A, "R4 mode1");
    pw(8'h00, 8'h20, "R4 blink only");
    pw(8'h03, 8'h08, "R5 mode2");
    pw(8'h13, 8'hF7, "R7 pal3");
    pw(8'h1F, 8'hAB, "R7 pal15");
    pw(8'h10, 8'h05, "R7 pal0");
    pw(8'h08, 8'hFF, "R8 idx08");
    pw(8'h20, 8'h33, "R8 idx20");
    pw(8'h0F, 8'h66, "R8 idx0F");
    op(1'b1, 1'b0, 1'b0, 8'h02, "R3 idx before read");
    op(1'b0, 1'b1, 1'b0, 8'h00, "R3 status read");
    op(1'b1, 1'b0, 1'b0, 8'h11, "R3 reindexed");
    op(1'b1, 1'b0, 1'b0, 8'h44, "R3 pal1");
    op(1'b1, 1'b1, 1'b0, 8'h00, "R3 idx with read");
    op(1'b1, 1'b0, 1'b0, 8'h02, "R3 still index");
    op(1'b1, 1'b0, 1'b0, 8'h77, "R3 border");
    op(1'b1, 1'b0, 1'b0, 8'h02, "R3 idx");
    op(1'b1, 1'b1, 1'b0, 8'h99, "R3 data with read");
    pw(8'h03, 8'h00, "R3 resynced mode2");
    op(1'b0, 1'b0, 1'b1, 8'hFF, "R9 even forced");
    op(1'b0, 1'b0, 1'b1, 8'h6B, "R10 narrow mask");
    op(1'b0, 1'b0, 1'b1, 8'h12, "R10 wide mask");
    op(1'b0, 1'b0, 1'b1, 8'hBF, "R11 base");
    op(1'b0, 1'b0, 1'b1, 8'h40, "R10 mask one");
    pw(8'h05, 8'h01, "R6 ext on");
    op(1'b0, 1'b0, 1'b1, 8'hFF, "R6 page while ext");
    pw(8'h05, 8'h00, "R6 ext off");
    op(1'b0, 1'b0, 1'b1, 8'h80, "R9 mask two");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule